// File: doc/BRIEF.md
# Flash Command Sequencer with Boot Lockout

This block sits behind an asynchronous flash-style bus (active-low chip enable, output enable and write enable, a 16-bit word address, 16-bit data) and turns it into operations on a word-wide memory array port. Reads pass straight through to the array. Writes are never stored directly. Each bus write cycle is one step of a keyed command sequence. A four-cycle sequence programs one word. Six-cycle sequences erase either the whole array or only the main region. The array itself sits outside the block. The block addresses it, writes single words with a one-cycle strobe, and requests a bulk clear of a region with one-cycle clear strobes.

After a program or erase starts, a busy counter stands in for the cell timing. During that time every enabled read returns a status word, so software can poll for completion. A sticky lock flag, set by a one-cycle request, protects the low boot region (word addresses below `BOOT_WORDS`, 0000H to 1FFFH by default) from programming and from whole-array erase. The main region (2000H to FFFFH) stays writable.

The bus controls `ce_n` and `we_n` cross into the clock domain through a `SYNC_STAGES`-deep synchronizer. Address and data must be held stable around each write strobe. The address of a write cycle is captured when the synchronized `we_n` falls while `ce_n` is low. The data is taken when `we_n` rises. The rise is the command event.

The command state machine has these states: `ST_READ` (idle), `ST_UNL1` (first key seen), `ST_UNL2` (second key seen), `ST_PSETUP` (program setup seen), `ST_EPRE` (erase setup seen), `ST_EUNL1` and `ST_EUNL2` (erase re-keying), `ST_PWRITE` (one-cycle word write), `ST_PBUSY` (program timing), `ST_EGO` (one-cycle region clear) and `ST_EBUSY` (erase timing).

The transitions are:
- `ST_READ` to `ST_UNL1` on AAH at 5555H.
- `ST_UNL1` to `ST_UNL2` on 55H at 2AAAH.
- `ST_UNL2` to `ST_PSETUP` on A0H at 5555H, or to `ST_EPRE` on 80H at 5555H.
- `ST_PSETUP` to `ST_PWRITE` on any write, or to `ST_READ` if that write is a locked boot address.
- `ST_EPRE` to `ST_EUNL1` on AAH at 5555H.
- `ST_EUNL1` to `ST_EUNL2` on 55H at 2AAAH.
- `ST_EUNL2` to `ST_EGO` on 10H or 30H at 5555H.
- `ST_PWRITE` to `ST_PBUSY`, and `ST_EGO` to `ST_EBUSY`, unconditionally.
- `ST_PBUSY` and `ST_EBUSY` to `ST_READ` when the counter expires.
- Any other write in a keyed state returns to `ST_READ`.

Top module: `flash_cmd_seq`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1; whenever `dq_oe` is 0, `dq_out` is 0.
- R2: In read mode an enabled read presents `mem_addr`=`addr` and returns the array word `mem_rdata` on `dq_out`.
- R3: The write cycles AAH@5555H, 55H@2AAAH, A0H@5555H, then D@T write word D to address T once (one `mem_we` pulse). Command codes are compared on `dq_in[7:0]` only.
- R4: The six cycles AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, 10H@5555H erase the whole array when unlocked. When locked, they erase only the main region and leave boot words unchanged.
- R5: The same six cycles ending in 30H@5555H set every main-region word to FFFFH and never touch the boot region.
- R6: While a program or erase is busy, an enabled read returns a status word. Bit 7 of that word is the complement of the target's bit 7 (a program's data bit 7, or 1 for an erase), and all other bits are 0.
- R7: A program stays busy for about `PGM_CYCLES` clocks and an erase for about `ERS_CYCLES` clocks. Afterwards the block is back in read mode and returns true array data.
- R8: A write that does not match the expected step returns the sequencer to read mode. Later writes without a fresh unlock change nothing.
- R9: A one-cycle `lock_req` sets `boot_locked`, which stays set until reset.
- R10: With `boot_locked`=1, a program aimed below `BOOT_WORDS` is dropped. No array write occurs and the block returns to read mode without going busy.
- R11: Bus write cycles issued while busy are ignored.
- R12: After reset the block is in read mode, `boot_locked`=0, and no array strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write strobe, active low |
| addr | input | ADDR_W | Bus word address |
| dq_in | input | DATA_W | Bus write data |
| dq_out | output | DATA_W | Bus read data (0 when not driven) |
| dq_oe | output | 1 | Bus output drive enable |
| lock_req | input | 1 | One-cycle request to lock the boot region |
| boot_locked | output | 1 | Sticky boot lock flag |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | DATA_W | Array write data |
| mem_we | output | 1 | One-cycle array word write strobe |
| mem_clr_main | output | 1 | One-cycle request to set the main region to all ones |
| mem_clr_boot | output | 1 | One-cycle request to set the boot region to all ones |
| mem_rdata | input | DATA_W | Array read data at `mem_addr` |

## Verification
Suppose the sequencer holds a wrong state. If it is stuck in a keyed state, the next stray write cycle starts an unwanted command. Readback then shows a word that differs from the model after the poll, or an immediate status word where true data was expected. If a busy state is entered wrongly or left late, the very first read sample returns a status word or the wrong bit 7. A wrong exit from busy shows up as a poll count outside the window. A lost or mis-set lock flag shows up on `boot_locked` at once. Its effect on the boot region appears on the first readback after the next program or erase.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PSETUP,
        ST_EPRE,
        ST_EUNL1,
        ST_EUNL2,
        ST_PWRITE,
        ST_PBUSY,
        ST_EGO,
        ST_EBUSY
    } seq_state_t;

    // keyed command addresses
    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    // command codes on the low data byte
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] SETUP_ERS  = 8'h80;
    localparam logic [7:0] SETUP_PGM  = 8'hA0;
    localparam logic [7:0] FIN_CHIP   = 8'h10;
    localparam logic [7:0] FIN_MAIN   = 8'h30;

endpackage

// File: rtl/fseq_sync.sv
module fseq_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int PW = WIDTH * STAGES;

    logic [PW-1:0] pipe;

    // controls are active low, so the chain resets to all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[PW-WIDTH-1:0], d};
        end
    end

    assign q = pipe[PW-1 -: WIDTH];

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/fseq_rdmux.sv
module fseq_rdmux #(
    parameter int DATA_W = 16
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic              poll_b7,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word    = '0;
        status_word[7] = poll_b7;
    end

    always_comb begin
        dq_oe = !ce_n && !oe_n && we_n;
        if (!dq_oe) begin
            dq_out = '0;
        end else if (busy) begin
            dq_out = status_word;
        end else begin
            dq_out = arr_word;
        end
    end

endmodule

// File: rtl/fseq_cmd.sv
module fseq_cmd
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BOOT_WORDS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              boot_locked,
    input  logic              tmr_done,
    output logic              busy,
    output logic              poll_b7,
    output logic              arr_we,
    output logic              clr_main,
    output logic              clr_boot,
    output logic              tmr_load,
    output logic              tmr_ers,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data
);
    localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_WORDS);
    localparam logic [ADDR_W-1:0] ADR_A    = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B    = ADDR_W'(KEY_ADDR_B);

    seq_state_t state, state_nx;
    logic       ers_chip;
    logic [7:0] code;
    logic       at_a, at_b, in_boot;

    assign code    = wr_data[7:0];
    assign at_a    = (wr_addr == ADR_A);
    assign at_b    = (wr_addr == ADR_B);
    assign in_boot = (wr_addr < BOOT_LIM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READ: begin
                if (wr_evt && at_a && code == KEY_FIRST) state_nx = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_evt) state_nx = (at_b && code == KEY_SECOND) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_evt) begin
                    if (at_a && code == SETUP_PGM)      state_nx = ST_PSETUP;
                    else if (at_a && code == SETUP_ERS) state_nx = ST_EPRE;
                    else                                state_nx = ST_READ;
                end
            end
            ST_PSETUP: begin
                if (wr_evt) state_nx = (boot_locked && in_boot) ? ST_READ : ST_PWRITE;
            end
            ST_EPRE: begin
                if (wr_evt) state_nx = (at_a && code == KEY_FIRST) ? ST_EUNL1 : ST_READ;
            end
            ST_EUNL1: begin
                if (wr_evt) state_nx = (at_b && code == KEY_SECOND) ? ST_EUNL2 : ST_READ;
            end
            ST_EUNL2: begin
                if (wr_evt) begin
                    state_nx = (at_a && (code == FIN_CHIP || code == FIN_MAIN)) ? ST_EGO : ST_READ;
                end
            end
            ST_PWRITE: state_nx = ST_PBUSY;
            ST_PBUSY:  if (tmr_done) state_nx = ST_READ;
            ST_EGO:    state_nx = ST_EBUSY;
            ST_EBUSY:  if (tmr_done) state_nx = ST_READ;
            default:   state_nx = ST_READ;
        endcase
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_addr <= '0;
            pgm_data <= '0;
            ers_chip <= 1'b0;
        end else if (wr_evt) begin
            if (state == ST_PSETUP) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
            if (state == ST_EUNL2) begin
                ers_chip <= (code == FIN_CHIP);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        poll_b7  = 1'b0;
        arr_we   = 1'b0;
        clr_main = 1'b0;
        clr_boot = 1'b0;
        tmr_load = 1'b0;
        tmr_ers  = 1'b0;
        unique case (state)
            ST_PWRITE: begin
                busy     = 1'b1;
                poll_b7  = ~pgm_data[7];
                arr_we   = 1'b1;
                tmr_load = 1'b1;
            end
            ST_PBUSY: begin
                busy    = 1'b1;
                poll_b7 = ~pgm_data[7];
            end
            ST_EGO: begin
                busy     = 1'b1;
                clr_main = 1'b1;
                clr_boot = ers_chip && !boot_locked;
                tmr_load = 1'b1;
                tmr_ers  = 1'b1;
            end
            ST_EBUSY: begin
                busy = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BOOT_WORDS  = 8192,
    parameter int PGM_CYCLES  = 2000,
    parameter int ERS_CYCLES  = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              lock_req,
    output logic              boot_locked,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_clr_main,
    output logic              mem_clr_boot,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TMAX = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] PGM_LD = CW'(PGM_CYCLES);
    localparam logic [CW-1:0] ERS_LD = CW'(ERS_CYCLES);

    logic [1:0]        ctl_s;
    logic              ce_s, we_s, we_prev;
    logic              wr_fall, wr_rise;
    logic [ADDR_W-1:0] cyc_addr;
    logic              seq_busy, poll_b7, tmr_load, tmr_ers, tmr_done;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;

    fseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ce_n, we_n}),
        .q    (ctl_s)
    );

    assign ce_s = ctl_s[1];
    assign we_s = ctl_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
        end else begin
            we_prev <= we_s;
        end
    end

    assign wr_fall = !ce_s && we_prev && !we_s;
    assign wr_rise = !ce_s && !we_prev && we_s;

    // address of the write cycle, taken on the falling strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_addr <= '0;
        end else if (wr_fall) begin
            cyc_addr <= addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_locked <= 1'b0;
        end else if (lock_req) begin
            boot_locked <= 1'b1;
        end
    end

    fseq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_evt     (wr_rise),
        .wr_addr    (cyc_addr),
        .wr_data    (dq_in),
        .boot_locked(boot_locked),
        .tmr_done   (tmr_done),
        .busy       (seq_busy),
        .poll_b7    (poll_b7),
        .arr_we     (mem_we),
        .clr_main   (mem_clr_main),
        .clr_boot   (mem_clr_boot),
        .tmr_load   (tmr_load),
        .tmr_ers    (tmr_ers),
        .pgm_addr   (pgm_addr),
        .pgm_data   (pgm_data)
    );

    fseq_timer #(.CW(CW)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_ers ? ERS_LD : PGM_LD),
        .done (tmr_done)
    );

    assign mem_addr  = mem_we ? pgm_addr : addr;
    assign mem_wdata = pgm_data;

    fseq_rdmux #(.DATA_W(DATA_W)) u_rd (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .busy    (seq_busy),
        .poll_b7 (poll_b7),
        .arr_word(mem_rdata),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BOOT_WORDS = 8192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              busy,
    input logic              boot_locked,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_clr_main,
    input logic              mem_clr_boot
);
    localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_WORDS);

    // R1: a disabled bus drives nothing
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

    // R6: polled status carries only bit 7
    a_r6_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[DATA_W-1:8] == '0 && dq_out[6:0] == '0));

    // R3: a word write is a single-cycle strobe
    a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R3: word write and region clear never coincide
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && (mem_clr_main || mem_clr_boot)));

    // R4: boot clear only with main clear and only when unlocked
    a_r4_boot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr_boot |-> (mem_clr_main && !boot_locked));

    // R5: the main clear is one cycle wide
    a_r5_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clr_main |=> !mem_clr_main);

    // R9: the lock never drops while out of reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R10: no word write below the boot limit while locked
    a_r10_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && boot_locked) |-> (mem_addr >= BOOT_LIM));

    // R7: any strobe happens inside a busy window
    a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_clr_main) |-> busy);

endmodule

bind flash_cmd_seq fseq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BOOT_WORDS(BOOT_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .dq_oe       (dq_oe),
    .dq_out      (dq_out),
    .busy        (seq_busy),
    .boot_locked (boot_locked),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_clr_main(mem_clr_main),
    .mem_clr_boot(mem_clr_boot)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PGM_C = 24;
    localparam int ERS_C = 80;
    localparam int BOOT  = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0, dq_in = '0;
    logic [15:0] dq_out;
    logic dq_oe;
    logic lock_req = 1'b0;
    logic boot_locked;
    logic [15:0] mem_addr, mem_wdata;
    logic mem_we, mem_clr_main, mem_clr_boot;
    logic [15:0] mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit locked_m = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_seq #(
        .PGM_CYCLES(PGM_C),
        .ERS_CYCLES(ERS_C),
        .BOOT_WORDS(BOOT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .lock_req(lock_req), .boot_locked(boot_locked),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_clr_main(mem_clr_main), .mem_clr_boot(mem_clr_boot),
        .mem_rdata(mem_rdata)
    );

    // array model attached to the array port
    logic [15:0] arr [int unsigned];
    int mem_gen = 0;

    always @(posedge clk) begin
        int unsigned k;
        if (mem_we) begin
            arr[32'(mem_addr)] = mem_wdata;
            mem_gen++;
        end
        if (mem_clr_main || mem_clr_boot) begin
            if (arr.first(k)) begin
                do begin
                    if ((k >= BOOT && mem_clr_main) || (k < BOOT && mem_clr_boot)) arr[k] = 16'hFFFF;
                end while (arr.next(k));
            end
            mem_gen++;
        end
    end

    always @(mem_addr or mem_gen) begin
        mem_rdata = arr.exists(32'(mem_addr)) ? arr[32'(mem_addr)] : 16'hFFFF;
    end

    // expected contents, built from the requirements
    logic [15:0] exp_m [int unsigned];

    function automatic logic [15:0] exp_rd(input logic [15:0] a);
        return exp_m.exists(32'(a)) ? exp_m[32'(a)] : 16'hFFFF;
    endfunction

    function automatic logic [15:0] status_of(input logic b7);
        logic [15:0] s;
        s = '0;
        s[7] = ~b7;
        return s;
    endfunction

    task automatic exp_clear(input bit main_r, input bit boot_r);
        int unsigned k;
        if (exp_m.first(k)) begin
            do begin
                if ((k >= BOOT && main_r) || (k < BOOT && boot_r)) exp_m[k] = 16'hFFFF;
            end while (exp_m.next(k));
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        d = dq_out;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic poll(input logic [15:0] a, input logic b7, input int limit,
                        output logic [15:0] first, output int n);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        first = dq_out;
        n = 0;
        while (dq_out[7] !== b7 && n < limit) begin
            @(negedge clk);
            #2;
            n++;
        end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic send_program(input logic [15:0] a, input logic [15:0] d);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h00A0);
        bus_write(a, d);
    endtask

    task automatic send_erase(input logic [7:0] fin);
        bus_write(16'h5555, 16'hFFAA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, 16'h0080);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, {8'h00, fin});
    endtask

    task automatic program_checked(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] first, rd;
        int n;
        send_program(a, d);
        if (locked_m && a < BOOT) begin
            bus_read(a, rd);
            check("R10 locked boot program dropped", rd, exp_rd(a));
        end else begin
            exp_m[32'(a)] = d;
            poll(a, d[7], PGM_C + 20, first, n);
            check("R6 program status word", first, status_of(d[7]));
            check("R7 program busy window", 32'(n >= 1 && n <= PGM_C + 8), 1);
            bus_read(a, rd);
            check("R3 programmed word", rd, d);
        end
    endtask

    task automatic verify_all(input string req);
        int unsigned k;
        logic [15:0] rd;
        if (exp_m.first(k)) begin
            do begin
                bus_read(16'(k), rd);
                check(req, rd, exp_m[k]);
            end while (exp_m.next(k));
        end
    endtask

    task automatic erase_checked(input bit chip, input string req);
        logic [15:0] first;
        int n;
        send_erase(chip ? 8'h10 : 8'h30);
        exp_clear(1'b1, chip && !locked_m);
        poll(16'h3000, 1'b1, ERS_C + 20, first, n);
        check("R6 erase status word", first, 16'h0000);
        check("R7 erase busy window", 32'(n >= 1 && n <= ERS_C + 8), 1);
        verify_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rd, a, d, first;
        int n;
        void'($urandom(32'h5EED1234));
        do_reset();

        // R12: reset state
        check("R12 lock clear after reset", boot_locked, 0);
        check("R12 no array strobes", {mem_we, mem_clr_main, mem_clr_boot}, 0);
        bus_read(16'h0040, rd);
        check("R2 R12 read mode after reset", rd, 16'hFFFF);

        // R1: output gating
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; #2;
        check("R1 ce high no drive", {dq_oe, dq_out}, 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; #2;
        check("R1 oe high no drive", {dq_oe, dq_out}, 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; #2;
        check("R1 enabled read drives", dq_oe, 1);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;

        // directed programs at region boundaries, then random ones
        program_checked(16'h1FFF, 16'h1234);
        program_checked(16'h2000, 16'h00FF);
        program_checked(16'h0000, 16'hA55A);
        program_checked(16'hFFFF, 16'h0080);
        for (int i = 0; i < 10; i++) begin
            a = 16'($urandom);
            if (i % 2 == 0) a = a % 16'(BOOT);
            d = 16'($urandom);
            program_checked(a, d);
        end

        // R2: pass-through of the array word
        bus_read(16'h1FFF, rd);
        check("R2 read returns array word", rd, 16'h1234);

        // R8: broken sequences
        for (int i = 0; i < 6; i++) begin
            a = 16'h2000 + 16'($urandom % 4096);
            d = 16'($urandom);
            bus_write(16'h5555, 16'h00AA);
            case (i % 3)
                0: bus_write(16'h2AAB, 16'h0055);
                1: bus_write(16'h2AAA, 16'h0056);
                default: bus_write(16'h2AAA, 16'h0055);
            endcase
            bus_write(16'h5555, (i % 3 == 2) ? 16'h0090 : 16'h00A0);
            bus_write(a, d);
            bus_read(a, rd);
            check("R8 aborted sequence writes nothing", rd, exp_rd(a));
        end

        // R5: main-region erase keeps boot words
        erase_checked(1'b0, "R5 main erase contents");

        // R4: unlocked chip erase clears both regions
        program_checked(16'h0100, 16'h0F0F);
        program_checked(16'h8000, 16'hBEEF);
        erase_checked(1'b1, "R4 unlocked chip erase contents");

        // R9: lock request
        program_checked(16'h0200, 16'h7E7E);
        program_checked(16'h0300, 16'hC3C3);
        program_checked(16'h4000, 16'h1111);
        @(negedge clk);
        lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0;
        locked_m = 1'b1;
        #2;
        check("R9 lock set", boot_locked, 1);

        // R10: boot program dropped, main program still works
        program_checked(16'h0200, 16'h0000);
        program_checked(16'h1FFF, 16'h5555);
        program_checked(16'h2000, 16'h2222);

        // R4: locked chip erase leaves boot data
        erase_checked(1'b1, "R4 locked chip erase contents");
        bus_read(16'h0300, rd);
        check("R4 boot word kept under lock", rd, 16'hC3C3);

        // R11: writes while erase is busy are ignored
        program_checked(16'h6000, 16'h0001);
        send_erase(8'h30);
        exp_clear(1'b1, 1'b0);
        send_program(16'h6000, 16'h1234);
        poll(16'h6000, 1'b1, ERS_C + 20, first, n);
        check("R11 still busy after ignored writes", first, 16'h0000);
        bus_read(16'h6000, rd);
        check("R11 program during busy ignored", rd, 16'hFFFF);
        check("R9 lock still set", boot_locked, 1);

        // R9 R12: reset clears the lock
        do_reset();
        locked_m = 1'b0;
        check("R9 R12 lock cleared by reset", boot_locked, 0);
        program_checked(16'h0010, 16'h4242);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule